// File: doc/BRIEF.md
# Strap-Latched Frequency Select Controller

This block sequences the power-up of a clock synthesizer and captures its two frequency-select straps exactly once. After the analog supply is reported good, a settling window is counted in ticks of a timebase. Only then is the active-low power-good strobe honoured. On the first clock edge that finds the strobe low, both strap levels are stored. A second tick-counted window follows, and then the clock outputs are enabled. Once the straps are stored, the strobe and the straps have no further effect until the supply goes away.

The stored selection is decoded into a three-bit CPU frequency code and an output-state code. A software-owned table bit swaps the normal frequency set for a faster alternate set, position for position. A mid-level second strap at sampling time puts the block into a test mode. In test mode the first strap selects, combinationally, between all outputs high-impedance and all outputs at reference divided by N. Test mode is left only by dropping the supply and sampling again with the second strap at a solid level. The stored strap bits are also presented for register readback.

Top module: `fsel_ctrl`

## Requirements
- R1: While rst_n is low and after its release, seq_state is 0, out_en is 0, test_mode is 0, latched_fs is 0 and out_mode is 0 (normal).
- R2: seq_state encodes the machine as 0 = off, 1 = waiting for strobe, 2 = sampling, 3 = running. With supply_ok high in state 0, the next clock edge enters state 1.
- R3: In state 1 the strobe is ignored until DLY_TICKS tick pulses have been counted there. With tick high on every cycle and pwrgd_n already low, state 2 is entered DLY_TICKS+1 edges after state 1 is entered, and the straps are stored on that edge.
- R4: out_en is high only in state 3. With tick high on every cycle, state 3 is reached EN_TICKS+1 edges after state 2 is entered.
- R5: After the straps are stored, changes on pwrgd_n, strap_a or strap_b change neither latched_fs, freq_code, seq_state nor out_en.
- R6: Strap levels are coded 00 = low, 01 = mid, 10 = high, 11 = treated as mid. A stored strap bit is 1 for high, and for strap_a also for mid, and 0 otherwise. latched_fs bit 0 holds strap_a's bit and bit 1 holds strap_b's bit.
- R7: Outside test mode freq_code = {alt_table, a_bit, b_bit}. With alt_table = 0 the codes 000/001/010/011 stand for 100/133/200/166 MHz.
- R8: alt_table acts immediately and selects the alternate set, in which codes 100/101/110/111 stand for 200/400/266/333 MHz.
- R9: A mid or 11 level on strap_b when the straps are stored sets test_mode, and freq_code is then 000.
- R10: In test mode out_mode follows strap_a without a clock: low gives 1 (high-impedance), any other level gives 2 (reference divided). strap_b is ignored.
- R11: supply_ok low returns the machine to state 0 on the next edge and clears latched_fs and test_mode. Sampling again with a solid strap_b leaves test mode.
- R12: Outside test mode out_mode is 0 (normal).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Analog supply good |
| pwrgd_n | input | 1 | Active-low power-good strobe |
| tick | input | 1 | One-cycle pulse of the delay timebase |
| strap_a | input | 2 | First frequency-select strap level |
| strap_b | input | 2 | Second frequency-select strap level |
| alt_table | input | 1 | Register bit selecting the alternate frequency set |
| freq_code | output | 3 | Decoded CPU frequency code |
| out_mode | output | 2 | Output state: 0 normal, 1 high-impedance, 2 reference divided |
| test_mode | output | 1 | Test clock mode active |
| out_en | output | 1 | Clock outputs enabled |
| seq_state | output | 2 | Power-up machine state |
| latched_fs | output | 2 | Stored strap bits for readback |

## Verification
All four solid strap combinations are applied under both tables. Each one must produce a distinct code, which shows that the two strap bits are neither swapped nor merged and that the table bit is the code's top bit. Mid and reserved levels on each strap are applied separately. This tells test-mode entry (second strap) apart from a mid level read as high (first strap). Strap and strobe toggling after capture, a strobe held low through the settling window, and a supply drop in mid-sequence separate the one-shot latch from a level-sensitive one. They also separate a correct window count from an off-by-one count.

// File: rtl/fsel_pkg.sv
// Shared codes for the strap-latched frequency select controller.
package fsel_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_WAIT   = 2'd1,
        ST_SAMPLE = 2'd2,
        ST_RUN    = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        OM_NORMAL = 2'd0,
        OM_HIZ    = 2'd1,
        OM_REFDIV = 2'd2
    } out_mode_e;

    localparam logic [1:0] LVL_LOW  = 2'b00;
    localparam logic [1:0] LVL_MID  = 2'b01;
    localparam logic [1:0] LVL_HIGH = 2'b10;

    localparam int NUM_STRAPS = 2;
endpackage

// File: rtl/fsel_seq.sv
// Power-up sequencer. It counts tick pulses in the waiting and sampling
// states, and produces the one-cycle capture strobe and the output enable.
// Assumes tick is synchronous to clk and supply_ok is already synchronised.
module fsel_seq
    import fsel_pkg::*;
#(
    parameter int DLY_TICKS = 250,
    parameter int EN_TICKS  = 1500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       pwrgd_n,
    input  logic       tick,
    output seq_state_e state,
    output logic       capture,
    output logic       out_en
);
    localparam int MAXT = (DLY_TICKS > EN_TICKS) ? DLY_TICKS : EN_TICKS;
    localparam int CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] DLY_C = CW'(DLY_TICKS);
    localparam logic [CW-1:0] EN_C  = CW'(EN_TICKS);
    localparam logic [CW-1:0] MAX_C = CW'(MAXT);

    seq_state_e    nxt;
    logic [CW-1:0] cnt;
    logic          dly_done;
    logic          en_done;

    assign dly_done = (cnt >= DLY_C);
    assign en_done  = (cnt >= EN_C);
    assign capture  = supply_ok && (state == ST_WAIT) && dly_done && !pwrgd_n;
    assign out_en   = (state == ST_RUN);

    // Next-state choice; a lost supply always wins.
    always_comb begin
        nxt = state;
        if (!supply_ok) begin
            nxt = ST_OFF;
        end else begin
            case (state)
                ST_OFF:    nxt = ST_WAIT;
                ST_WAIT:   if (capture) nxt = ST_SAMPLE;
                ST_SAMPLE: if (en_done) nxt = ST_RUN;
                default:   nxt = ST_RUN;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // Tick counter, cleared on each state change and saturating at its limit.
    always_ff @(posedge clk) begin
        if (!rst_n || (nxt != state)) cnt <= '0;
        else if (tick && (cnt < MAX_C)) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/fsel_latch.sv
// One-shot strap store. It reduces each strap level to a bit, flags a
// mid-level second strap as test mode, and holds the result until cleared.
// Assumes capture is asserted for at most one cycle per power-up.
module fsel_latch
    import fsel_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       capture,
    input  logic [NUM_STRAPS-1:0][1:0] straps,
    output logic [NUM_STRAPS-1:0]      sel_bits,
    output logic                       test_mode
);
    logic [NUM_STRAPS-1:0] lvl_bit;
    logic                  b_not_solid;

    // Per-strap reduction: strap 0 reads any non-low level as 1,
    // the other straps read only the high level as 1.
    for (genvar i = 0; i < NUM_STRAPS; i++) begin : g_lvl
        if (i == 0) begin : g_first
            assign lvl_bit[i] = (straps[i] != LVL_LOW);
        end else begin : g_other
            assign lvl_bit[i] = (straps[i] == LVL_HIGH);
        end
    end

    assign b_not_solid = (straps[1] != LVL_LOW) && (straps[1] != LVL_HIGH);

    // Store selection and test flag on capture; clear on supply loss.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sel_bits  <= '0;
            test_mode <= 1'b0;
        end else if (capture) begin
            sel_bits  <= lvl_bit;
            test_mode <= b_not_solid;
        end
    end
endmodule

// File: rtl/fsel_decode.sv
// Decodes the stored selection into a frequency code and an output state.
// In test mode the output state follows the live first strap without a clock.
module fsel_decode
    import fsel_pkg::*;
(
    input  logic       sel_a,
    input  logic       sel_b,
    input  logic       test_mode,
    input  logic       alt_table,
    input  logic [1:0] strap_a,
    output logic [2:0] freq_code,
    output out_mode_e  out_mode
);
    // Frequency code and output state selection.
    always_comb begin
        if (test_mode) begin
            freq_code = 3'b000;
            out_mode  = (strap_a == LVL_LOW) ? OM_HIZ : OM_REFDIV;
        end else begin
            freq_code = {alt_table, sel_a, sel_b};
            out_mode  = OM_NORMAL;
        end
    end
endmodule

// File: rtl/fsel_ctrl.sv
// Top of the strap-latched frequency select controller: sequencer,
// one-shot strap store and decoder. Assumes all inputs are synchronous to clk.
module fsel_ctrl
    import fsel_pkg::*;
#(
    parameter int DLY_TICKS = 250,
    parameter int EN_TICKS  = 1500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       pwrgd_n,
    input  logic       tick,
    input  logic [1:0] strap_a,
    input  logic [1:0] strap_b,
    input  logic       alt_table,
    output logic [2:0] freq_code,
    output logic [1:0] out_mode,
    output logic       test_mode,
    output logic       out_en,
    output logic [1:0] seq_state,
    output logic [1:0] latched_fs
);
    seq_state_e                  st;
    logic                        capture;
    logic [NUM_STRAPS-1:0]       sel_bits;
    logic [NUM_STRAPS-1:0][1:0]  straps;
    out_mode_e                   om;

    assign straps = {strap_b, strap_a};

    fsel_seq #(.DLY_TICKS(DLY_TICKS), .EN_TICKS(EN_TICKS)) u_seq (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pwrgd_n(pwrgd_n),
        .tick(tick), .state(st), .capture(capture), .out_en(out_en)
    );

    fsel_latch u_latch (
        .clk(clk), .rst_n(rst_n), .clear(!supply_ok), .capture(capture),
        .straps(straps), .sel_bits(sel_bits), .test_mode(test_mode)
    );

    fsel_decode u_dec (
        .sel_a(sel_bits[0]), .sel_b(sel_bits[1]), .test_mode(test_mode),
        .alt_table(alt_table), .strap_a(strap_a),
        .freq_code(freq_code), .out_mode(om)
    );

    assign out_mode   = om;
    assign seq_state  = st;
    assign latched_fs = sel_bits;
endmodule

// File: rtl/fsel_ctrl_chk.sv
// Property checker for fsel_ctrl, attached by bind.
module fsel_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       supply_ok,
    input logic       pwrgd_n,
    input logic [1:0] strap_a,
    input logic [1:0] seq_state,
    input logic [1:0] latched_fs,
    input logic       test_mode,
    input logic [1:0] out_mode,
    input logic [2:0] freq_code,
    input logic       out_en
);
    AST_SUPPLY_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (seq_state == 2'd0) && (latched_fs == 2'd0) && !test_mode); // R11

    AST_ENTER_SAMPLE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 2'd2) && ($past(seq_state) == 2'd1) |-> !$past(pwrgd_n)); // R3

    AST_ENABLE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_en) |-> ($past(seq_state) == 2'd2)); // R4

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        seq_state[1] && $past(seq_state[1]) |-> $stable(latched_fs)); // R5

    AST_TEST_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode && (strap_a == 2'b00) |-> (out_mode == 2'd1)); // R10

    AST_TEST_NO_CPU_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> (freq_code == 3'b000)); // R9

    AST_NORMAL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |-> (out_mode == 2'd0)); // R12
endmodule

bind fsel_ctrl fsel_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pwrgd_n(pwrgd_n),
    .strap_a(strap_a), .seq_state(seq_state), .latched_fs(latched_fs),
    .test_mode(test_mode), .out_mode(out_mode), .freq_code(freq_code),
    .out_en(out_en)
);

// File: tb/fsel_ctrl_tb.sv
module fsel_ctrl_tb;
    localparam int DLY = 6;
    localparam int ENT = 4;
    localparam logic [1:0] LO = 2'b00, MD = 2'b01, HI = 2'b10, RS = 2'b11;

    logic clk = 1'b0;
    logic rst_n, supply_ok, pwrgd_n, tick, alt_table;
    logic [1:0] strap_a, strap_b;
    logic [2:0] freq_code;
    logic [1:0] out_mode, seq_state, latched_fs;
    logic test_mode, out_en;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fsel_ctrl #(.DLY_TICKS(DLY), .EN_TICKS(ENT)) u_dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pwrgd_n(pwrgd_n),
        .tick(tick), .strap_a(strap_a), .strap_b(strap_b), .alt_table(alt_table),
        .freq_code(freq_code), .out_mode(out_mode), .test_mode(test_mode),
        .out_en(out_en), .seq_state(seq_state), .latched_fs(latched_fs)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Power cycle, set straps, wait out the window, drop the strobe, reach run.
    task automatic bring_up(input logic [1:0] a, input logic [1:0] b);
        @(negedge clk);
        supply_ok = 1'b0; pwrgd_n = 1'b1; strap_a = a; strap_b = b;
        @(negedge clk);
        supply_ok = 1'b1;
        repeat (DLY + 3) @(negedge clk);
        pwrgd_n = 1'b0;
        for (int i = 0; i < 50 && seq_state != 2'd3; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 state", seq_state, 0);
        chk("R1 out_en", out_en, 0);
        chk("R1 test_mode", test_mode, 0);
        chk("R1 latched_fs", latched_fs, 0);
        chk("R1 out_mode", out_mode, 0);
    endtask

    task automatic t_table();
        logic [1:0] lv [2];
        lv[0] = LO; lv[1] = HI;
        for (int ia = 0; ia < 2; ia++) begin
            for (int ib = 0; ib < 2; ib++) begin
                alt_table = 1'b0;
                bring_up(lv[ia], lv[ib]);
                chk("R4 out_en in run", out_en, 1);
                chk("R6 latched_fs", latched_fs, ib * 2 + ia);
                chk("R7 normal freq_code", freq_code, ia * 2 + ib);
                chk("R12 out_mode normal", out_mode, 0);
                @(negedge clk); alt_table = 1'b1; #1;
                chk("R8 alt freq_code", freq_code, 4 + ia * 2 + ib);
                alt_table = 1'b0;
            end
        end
    endtask

    task automatic t_delay();
        int n;
        @(negedge clk);
        supply_ok = 1'b0; pwrgd_n = 1'b0; strap_a = HI; strap_b = HI;
        @(negedge clk);
        chk("R11 off after drop", seq_state, 0);
        supply_ok = 1'b1;
        @(negedge clk);
        chk("R2 wait state after supply", seq_state, 1);
        chk("R3 no capture during window", latched_fs, 0);
        n = 0;
        while (seq_state != 2'd2 && n < 100) begin @(negedge clk); n++; end
        chk("R3 edges to sample", n, DLY + 1);
        chk("R4 out_en low in sample", out_en, 0);
        chk("R3 straps stored", latched_fs, 3);
        n = 0;
        while (seq_state != 2'd3 && n < 100) begin @(negedge clk); n++; end
        chk("R4 edges to run", n, ENT + 1);
        chk("R4 out_en high", out_en, 1);
    endtask

    task automatic t_oneshot();
        bring_up(HI, LO);
        @(negedge clk);
        strap_a = LO; strap_b = HI; pwrgd_n = 1'b1;
        repeat (3) @(negedge clk);
        pwrgd_n = 1'b0;
        repeat (2) @(negedge clk);
        pwrgd_n = 1'b1; strap_b = MD;
        repeat (DLY + 2) @(negedge clk);
        chk("R5 latched_fs held", latched_fs, 1);
        chk("R5 freq_code held", freq_code, 2);
        chk("R5 state held", seq_state, 3);
        chk("R5 out_en held", out_en, 1);
        chk("R5 no test entry", test_mode, 0);
    endtask

    task automatic t_test_mode();
        bring_up(LO, MD);
        chk("R9 test entered", test_mode, 1);
        chk("R9 freq_code zero", freq_code, 0);
        chk("R10 hiz", out_mode, 1);
        @(negedge clk); strap_a = HI; #1;
        chk("R10 refdiv without clock", out_mode, 2);
        strap_a = MD; #1;
        chk("R10 mid gives refdiv", out_mode, 2);
        @(negedge clk); strap_b = LO;
        repeat (3) @(negedge clk);
        chk("R10 strap_b ignored", test_mode, 1);
        bring_up(HI, LO);
        chk("R11 test left", test_mode, 0);
        chk("R11 normal after exit", out_mode, 0);
        chk("R11 freq after exit", freq_code, 2);
        bring_up(LO, RS);
        chk("R9 reserved level enters test", test_mode, 1);
    endtask

    task automatic t_supply_drop();
        @(negedge clk);
        supply_ok = 1'b0; pwrgd_n = 1'b1; strap_a = HI; strap_b = HI;
        @(negedge clk); supply_ok = 1'b1;
        repeat (DLY + 3) @(negedge clk);
        pwrgd_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 in sample", seq_state, 2);
        supply_ok = 1'b0;
        @(negedge clk);
        chk("R11 state off", seq_state, 0);
        chk("R11 latch cleared", latched_fs, 0);
        chk("R11 out_en low", out_en, 0);
    endtask

    task automatic t_a_mid();
        bring_up(MD, LO);
        chk("R6 mid on strap_a reads 1", latched_fs, 1);
        chk("R6 no test from strap_a", test_mode, 0);
        bring_up(HI, MD);
        chk("R6 strap_b mid bit 0", latched_fs, 1);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; supply_ok = 1'b0; pwrgd_n = 1'b1; tick = 1'b1;
        alt_table = 1'b0; strap_a = LO; strap_b = LO;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_table();
        t_delay();
        t_oneshot();
        t_test_mode();
        t_supply_drop();
        t_a_mid();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule